// File: doc/BRIEF.md
# Interleaved-Segment Grayscale PWM Generator

This block turns a 16-bit grayscale value per channel into an on/off enable for twelve LED channels. A single frame counter spans 2^GS_W reference clocks, and the frame is cut into 2^SEG_W equal segments. A channel does not get one long pulse per frame. Each segment instead turns the channel on for a short run at the start of the segment, and the runs add up to the grayscale value. The upper grayscale bits set the run length in every segment. The lower bits add one extra clock to a subset of segments. Those segments are picked in bit-reversed index order, so the extra on-time is spread evenly over the frame.

The reference clock comes from one of two level sources: a free-running oscillator or an external clock. Either its rising or its falling transitions drive the counter and the outputs. A controller loads new grayscale words with a latch strobe. The strobe can also restart the frame. A blank level, a single-frame/auto-repeat choice and an overtemperature flag control when the outputs may be on.

The controller is a four-state machine:
- BLANK holds the counter at zero with outputs off.
- RUN counts and drives the outputs.
- HOT counts with outputs off during overtemperature.
- DONE follows a finished single frame with outputs off.

Transitions:
- Any state goes to BLANK while blank is high.
- BLANK goes to RUN, or to HOT if the flag is set, once blank is low.
- RUN goes to HOT when the flag rises.
- RUN goes to DONE at the last clock of a frame when auto-repeat is clear.
- HOT goes to RUN, or to DONE without auto-repeat, at a frame wrap with the flag clear.
- DONE goes to RUN, or HOT, on a timing-reset latch strobe.

Top module: `esp_pwm_gen`

## Requirements
- R1: After reset, while blank is high, every chan_on bit is 0 whatever the reference clocks and latch strobe do.
- R2: Number the clocks of a frame k = 0 .. 2^GS_W-1. Take seg = k >> (GS_W-SEG_W) and loc = k mod 2^(GS_W-SEG_W), and let rev be seg with its SEG_W bits reversed. Channel i with grayscale g (bits [i*GS_W +: GS_W] of gs_data) is on for clock k exactly when loc < g[GS_W-1:SEG_W] + (rev < g[SEG_W-1:0] ? 1 : 0). The value for clock k appears on chan_on at the system clock edge that sees the (k+1)-th active reference transition, and it holds until the next one.
- R3: Over one full frame a channel is on for exactly g clocks, so g = 0 never turns it on.
- R4: At full scale (all ones) a channel is on for 2^(GS_W-SEG_W) clocks in every segment but the last, and one clock fewer in the last segment.
- R5: With edge_rise = 1 the rising transitions of the selected reference advance the frame; with edge_rise = 0 the falling transitions do. The opposite transition leaves chan_on unchanged.
- R6: ref_sel = 1 selects ext_ref and ref_sel = 0 selects osc_ref. Activity on the unselected source leaves chan_on and the frame position untouched.
- R7: Blank high forces chan_on to 0 at the next edge and holds the frame position at 0. After blank falls, the frame starts at clock 0.
- R8: With auto_repeat = 1 the frame restarts seamlessly after its last clock. With auto_repeat = 0, chan_on stays 0 after the last clock of the frame.
- R9: A latch strobe with tmg_reset = 1 forces chan_on to 0 and restarts the frame at clock 0, and this also works from the finished state. With tmg_reset = 0 the frame position continues.
- R10: Grayscale words take effect only on a latch strobe. A change of gs_data without a strobe has no effect.
- R11: over_temp high forces chan_on to 0 at the next edge. After it clears, outputs stay off until the first clock of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_ref | input | 1 | Internal oscillator reference level |
| ext_ref | input | 1 | External reference clock level |
| ref_sel | input | 1 | 1 selects ext_ref, 0 selects osc_ref |
| edge_rise | input | 1 | 1: rising transitions are active; 0: falling |
| blank | input | 1 | Forces outputs off and holds the frame at 0 |
| auto_repeat | input | 1 | 1 repeats frames; 0 runs a single frame |
| tmg_reset | input | 1 | Latch strobe also restarts the frame |
| latch_pulse | input | 1 | One-cycle strobe loading gs_data |
| over_temp | input | 1 | Overtemperature flag |
| gs_data | input | NCH*GS_W | Grayscale words, channel i at [i*GS_W +: GS_W] |
| chan_on | output | NCH | Per-channel output enable |

## Verification
The reference level is set on the falling system edge. The design sees the transition at the next rising edge, and the frame counter and chan_on change at that same edge. The bench therefore reads chan_on at the falling edge one cycle after each active transition. It reads it again one cycle after the inactive transition to confirm that nothing moved. Blank, overtemperature and the latch strobe also act at the first rising edge after they are driven, so their effect is checked at the following falling edge. The bench waits two cycles after blank falls before the first active transition, because the release cycle itself lets no output through.

// File: rtl/esp_pkg.sv
package esp_pkg;

    // Frame controller states
    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOT   = 2'd2,
        ST_DONE  = 2'd3
    } esp_state_t;

endpackage

// File: rtl/esp_ref_edge.sv
// Selects one reference level source and turns the chosen transition
// polarity into a single-cycle advance strobe.
module esp_ref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_ref,
    input  logic ext_ref,
    input  logic ref_sel,
    input  logic edge_rise,
    output logic tick
);
    logic cur_lvl;
    logic prev_lvl;

    always_comb begin
        cur_lvl = ref_sel ? ext_ref : osc_ref;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= 1'b0;
        end else begin
            prev_lvl <= cur_lvl;
        end
    end

    always_comb begin
        if (edge_rise) begin
            tick = cur_lvl & ~prev_lvl;
        end else begin
            tick = ~cur_lvl & prev_lvl;
        end
    end

endmodule

// File: rtl/esp_frame_fsm.sv
// Frame controller: state register plus frame counter, and a single
// combinational process for next state and per-cycle commands.
module esp_frame_fsm #(
    parameter int GS_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   blank,
    input  logic                   auto_repeat,
    input  logic                   tmg_reset,
    input  logic                   latch_pulse,
    input  logic                   over_temp,
    output logic [GS_W-1:0]        cnt,
    output logic                   upd,
    output logic                   clr,
    output esp_pkg::esp_state_t    state
);
    import esp_pkg::*;

    localparam logic [GS_W-1:0] CNT_LAST = '1;

    esp_state_t       st_q, st_n;
    logic [GS_W-1:0]  cnt_q, cnt_n;
    logic             restart;
    logic             at_last;

    assign restart = latch_pulse & tmg_reset;
    assign at_last = (cnt_q == CNT_LAST);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_BLANK;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // Next state and commands
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        upd   = 1'b0;
        clr   = 1'b0;
        if (blank) begin
            st_n  = ST_BLANK;
            cnt_n = '0;
            clr   = 1'b1;
        end else begin
            unique case (st_q)
                ST_BLANK: begin
                    clr   = 1'b1;
                    cnt_n = '0;
                    st_n  = over_temp ? ST_HOT : ST_RUN;
                end
                ST_RUN: begin
                    if (over_temp) begin
                        st_n = ST_HOT;
                        clr  = 1'b1;
                        if (restart) begin
                            cnt_n = '0;
                        end else if (tick) begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end else if (restart) begin
                        cnt_n = '0;
                        clr   = 1'b1;
                    end else if (tick) begin
                        upd   = 1'b1;
                        cnt_n = cnt_q + 1'b1;
                        if (at_last && !auto_repeat) begin
                            st_n = ST_DONE;
                        end
                    end
                end
                ST_HOT: begin
                    clr = 1'b1;
                    if (restart) begin
                        cnt_n = '0;
                    end else if (tick) begin
                        cnt_n = cnt_q + 1'b1;
                        if (at_last && !over_temp) begin
                            st_n = auto_repeat ? ST_RUN : ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    clr = 1'b1;
                    if (restart) begin
                        cnt_n = '0;
                        st_n  = over_temp ? ST_HOT : ST_RUN;
                    end
                end
                default: begin
                    st_n  = ST_BLANK;
                    cnt_n = '0;
                    clr   = 1'b1;
                end
            endcase
        end
    end

    assign cnt   = cnt_q;
    assign state = st_q;

endmodule

// File: rtl/esp_chan_slice.sv
// One output channel: segment-local compare with a bit-reversed
// extra-clock rule, registered enable.
module esp_chan_slice #(
    parameter int GS_W  = 16,
    parameter int SEG_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [GS_W-1:0] cnt,
    input  logic [GS_W-1:0] gs,
    input  logic            upd,
    input  logic            clr,
    output logic            on
);
    localparam int LOC_W = GS_W - SEG_W;

    logic [SEG_W-1:0] seg_idx;
    logic [SEG_W-1:0] seg_rev;
    logic [LOC_W-1:0] loc_idx;
    logic [LOC_W:0]   thresh;
    logic             extra;
    logic             hit;

    assign seg_idx = cnt[GS_W-1:LOC_W];
    assign loc_idx = cnt[LOC_W-1:0];

    always_comb begin
        seg_rev = '0;
        for (int b = 0; b < SEG_W; b++) begin
            seg_rev[b] = seg_idx[SEG_W-1-b];
        end
    end

    assign extra  = (seg_rev < gs[SEG_W-1:0]);
    assign thresh = {1'b0, gs[GS_W-1:SEG_W]} + {{LOC_W{1'b0}}, extra};
    assign hit    = ({1'b0, loc_idx} < thresh);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on <= 1'b0;
        end else if (clr) begin
            on <= 1'b0;
        end else if (upd) begin
            on <= hit;
        end
    end

endmodule

// File: rtl/esp_pwm_gen.sv
// Top: reference edge select, frame controller, grayscale hold
// registers and one compare slice per channel.
module esp_pwm_gen #(
    parameter int NCH   = 12,
    parameter int GS_W  = 16,
    parameter int SEG_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  osc_ref,
    input  logic                  ext_ref,
    input  logic                  ref_sel,
    input  logic                  edge_rise,
    input  logic                  blank,
    input  logic                  auto_repeat,
    input  logic                  tmg_reset,
    input  logic                  latch_pulse,
    input  logic                  over_temp,
    input  logic [NCH*GS_W-1:0]   gs_data,
    output logic [NCH-1:0]        chan_on
);
    import esp_pkg::*;

    logic                       ref_tick;
    logic [GS_W-1:0]            frame_cnt;
    logic                       out_upd;
    logic                       out_clr;
    esp_state_t                 fsm_state;
    logic [NCH-1:0][GS_W-1:0]   gs_hold;

    esp_ref_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_ref   (osc_ref),
        .ext_ref   (ext_ref),
        .ref_sel   (ref_sel),
        .edge_rise (edge_rise),
        .tick      (ref_tick)
    );

    esp_frame_fsm #(.GS_W(GS_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (ref_tick),
        .blank       (blank),
        .auto_repeat (auto_repeat),
        .tmg_reset   (tmg_reset),
        .latch_pulse (latch_pulse),
        .over_temp   (over_temp),
        .cnt         (frame_cnt),
        .upd         (out_upd),
        .clr         (out_clr),
        .state       (fsm_state)
    );

    // Grayscale hold registers: only the latch strobe writes them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gs_hold <= '0;
        end else if (latch_pulse) begin
            for (int c = 0; c < NCH; c++) begin
                gs_hold[c] <= gs_data[c*GS_W +: GS_W];
            end
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        esp_chan_slice #(.GS_W(GS_W), .SEG_W(SEG_W)) u_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (frame_cnt),
            .gs    (gs_hold[ch]),
            .upd   (out_upd),
            .clr   (out_clr),
            .on    (chan_on[ch])
        );
    end

endmodule

// File: rtl/esp_pwm_chk.sv
// Checker bound to esp_pwm_gen.
module esp_pwm_chk #(
    parameter int NCH  = 12,
    parameter int GS_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     blank,
    input logic                     over_temp,
    input logic                     latch_pulse,
    input logic                     tmg_reset,
    input logic                     tick,
    input logic [GS_W-1:0]          cnt,
    input esp_pkg::esp_state_t      state,
    input logic [NCH-1:0][GS_W-1:0] gs_hold,
    input logic [NCH-1:0]           chan_on
);
    import esp_pkg::*;

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (chan_on == '0)); // R7

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (cnt == '0)); // R7

    AST_HOT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |=> (chan_on == '0)); // R11

    AST_TRST_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_pulse && tmg_reset) |=> (chan_on == '0)); // R9

    AST_TRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_pulse && tmg_reset) |=> (cnt == '0)); // R9

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_pulse |=> $stable(gs_hold)); // R10

    AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !latch_pulse && !blank && !over_temp) |=> $stable(chan_on)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !latch_pulse && !blank && (state == ST_RUN || state == ST_HOT))
        |=> (cnt == GS_W'($past(cnt) + 1'b1))); // R2

endmodule

bind esp_pwm_gen esp_pwm_chk #(.NCH(NCH), .GS_W(GS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .blank       (blank),
    .over_temp   (over_temp),
    .latch_pulse (latch_pulse),
    .tmg_reset   (tmg_reset),
    .tick        (ref_tick),
    .cnt         (frame_cnt),
    .state       (fsm_state),
    .gs_hold     (gs_hold),
    .chan_on     (chan_on)
);

// File: tb/sim_esp_pwm_gen.sv
module sim_esp_pwm_gen;
    localparam int CLK_P = 10;
    localparam int NCH   = 12;
    localparam int GS_W  = 8;
    localparam int SEG_W = 3;
    localparam int LOC_W = GS_W - SEG_W;
    localparam int FRAME = 1 << GS_W;
    localparam int SEGLEN = 1 << LOC_W;

    logic clk = 1'b0;
    logic rst_n, osc_ref, ext_ref, ref_sel, edge_rise, blank;
    logic auto_repeat, tmg_reset, latch_pulse, over_temp;
    logic [NCH*GS_W-1:0] gs_data;
    logic [NCH-1:0] chan_on;

    int tests = 0;
    int fails = 0;
    int gsv[NCH];
    int cur[NCH];
    int on_cnt[NCH];
    int first_seg[NCH];
    int last_seg[NCH];

    always #(CLK_P/2) clk = ~clk;

    esp_pwm_gen #(.NCH(NCH), .GS_W(GS_W), .SEG_W(SEG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_ref(osc_ref), .ext_ref(ext_ref),
        .ref_sel(ref_sel), .edge_rise(edge_rise), .blank(blank),
        .auto_repeat(auto_repeat), .tmg_reset(tmg_reset),
        .latch_pulse(latch_pulse), .over_temp(over_temp),
        .gs_data(gs_data), .chan_on(chan_on)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h (t=%0t)", req, got, exp, $time);
        end
    endtask

    function automatic bit exp_bit(input int g, input int k);
        int seg, loc, rev, thr;
        seg = k >> LOC_W;
        loc = k % SEGLEN;
        rev = 0;
        for (int b = 0; b < SEG_W; b++) rev = rev * 2 + ((seg >> b) & 1);
        thr = (g >> SEG_W) + ((rev < (g % (1 << SEG_W))) ? 1 : 0);
        return (loc < thr);
    endfunction

    function automatic logic [NCH-1:0] exp_vec(input int k);
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i] = exp_bit(cur[i], k);
        return v;
    endfunction

    task automatic apply_gs();
        for (int i = 0; i < NCH; i++) gs_data[i*GS_W +: GS_W] = GS_W'(gsv[i]);
    endtask

    task automatic do_latch();
        @(negedge clk);
        latch_pulse = 1'b1;
        @(negedge clk);
        latch_pulse = 1'b0;
        for (int i = 0; i < NCH; i++) cur[i] = gsv[i];
    endtask

    task automatic set_ref(input logic lvl);
        if (ref_sel) ext_ref = lvl;
        else         osc_ref = lvl;
    endtask

    // One reference period: active transition, sample, inactive, recheck
    task automatic gck(output logic [NCH-1:0] v);
        set_ref(edge_rise);
        @(negedge clk);
        v = chan_on;
        set_ref(~edge_rise);
        @(negedge clk);
        chk(chan_on == v, "R5 inactive transition", int'(chan_on), int'(v));
    endtask

    task automatic run_frame(input int k0, input int k1, input string req);
        logic [NCH-1:0] v, e;
        if (k0 == 0) begin
            for (int i = 0; i < NCH; i++) begin
                on_cnt[i] = 0; first_seg[i] = 0; last_seg[i] = 0;
            end
        end
        for (int k = k0; k < k1; k++) begin
            gck(v);
            e = exp_vec(k);
            chk(v == e, req, int'(v), int'(e));
            for (int i = 0; i < NCH; i++) begin
                if (v[i]) begin
                    on_cnt[i]++;
                    if (k < SEGLEN) first_seg[i]++;
                    if (k >= FRAME - SEGLEN) last_seg[i]++;
                end
            end
        end
    endtask

    task automatic restart_mode(input logic sel, input logic rise);
        blank = 1'b1;
        @(negedge clk);
        ref_sel = sel;
        edge_rise = rise;
        osc_ref = ~rise;
        ext_ref = ~rise;
        repeat (3) @(negedge clk);
        blank = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [NCH-1:0] v;
        rst_n = 1'b0; blank = 1'b1; osc_ref = 1'b0; ext_ref = 1'b0;
        ref_sel = 1'b1; edge_rise = 1'b1; auto_repeat = 1'b1;
        tmg_reset = 1'b1; latch_pulse = 1'b0; over_temp = 1'b0;
        gs_data = '0;
        for (int i = 0; i < NCH; i++) cur[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(chan_on == '0, "R1 reset", int'(chan_on), 0);

        // R1: blank held, full-scale data latched, references toggling
        for (int i = 0; i < NCH; i++) gsv[i] = FRAME - 1;
        apply_gs();
        do_latch();
        for (int j = 0; j < 6; j++) begin
            gck(v);
            chk(v == '0, "R1 blank after reset", int'(v), 0);
        end
        blank = 1'b0;
        repeat (2) @(negedge clk);

        // R2/R3: every grayscale value across the channels
        for (int f = 0; f < 22; f++) begin
            for (int i = 0; i < NCH; i++) gsv[i] = (f * NCH + i) % FRAME;
            apply_gs();
            do_latch();
            run_frame(0, FRAME, "R2 position");
            for (int i = 0; i < NCH; i++)
                chk(on_cnt[i] == cur[i], "R3 frame total", on_cnt[i], cur[i]);
        end

        // R4: full scale per-segment counts
        for (int i = 0; i < NCH; i++) gsv[i] = FRAME - 1;
        apply_gs();
        do_latch();
        run_frame(0, FRAME, "R4 position");
        for (int i = 0; i < NCH; i++) begin
            chk(first_seg[i] == SEGLEN, "R4 first segment", first_seg[i], SEGLEN);
            chk(last_seg[i] == SEGLEN - 1, "R4 last segment", last_seg[i], SEGLEN - 1);
        end

        // R10: new data without strobe is ignored (frame repeats with old data)
        for (int i = 0; i < NCH; i++) gsv[i] = 3;
        apply_gs();
        run_frame(0, FRAME, "R10 no strobe");

        // R8: single frame then dark
        auto_repeat = 1'b0;
        for (int i = 0; i < NCH; i++) gsv[i] = FRAME - 1 - i;
        apply_gs();
        do_latch();
        run_frame(0, FRAME, "R8 single frame");
        for (int j = 0; j < 20; j++) begin
            gck(v);
            chk(v == '0, "R8 after frame", int'(v), 0);
        end

        // R9: timing-reset strobe restarts from finished state
        do_latch();
        chk(chan_on == '0, "R9 strobe dark", int'(chan_on), 0);
        run_frame(0, FRAME, "R9 restart from done");
        auto_repeat = 1'b1;
        do_latch();
        run_frame(0, 10, "R9 before no-reset strobe");
        for (int i = 0; i < NCH; i++) gsv[i] = 8'h50;
        apply_gs();
        tmg_reset = 1'b0;
        do_latch();
        tmg_reset = 1'b1;
        run_frame(10, FRAME, "R9 position kept");
        run_frame(0, 40, "R9 mid frame");
        do_latch();
        chk(chan_on == '0, "R9 mid-frame strobe dark", int'(chan_on), 0);
        run_frame(0, FRAME, "R9 after mid-frame restart");

        // R11: overtemperature
        for (int i = 0; i < NCH; i++) gsv[i] = FRAME - 1 - 3 * i;
        apply_gs();
        do_latch();
        run_frame(0, 60, "R11 before");
        @(negedge clk);
        over_temp = 1'b1;
        @(negedge clk);
        over_temp = 1'b0;
        chk(chan_on == '0, "R11 flag dark", int'(chan_on), 0);
        for (int k = 60; k < FRAME; k++) begin
            gck(v);
            chk(v == '0, "R11 rest of frame", int'(v), 0);
        end
        run_frame(0, FRAME, "R11 next frame");

        // R7: blank mid-frame
        run_frame(0, 30, "R7 before");
        blank = 1'b1;
        for (int j = 0; j < 5; j++) begin
            gck(v);
            chk(v == '0, "R7 blanked", int'(v), 0);
        end
        blank = 1'b0;
        repeat (2) @(negedge clk);
        run_frame(0, FRAME, "R7 restart");

        // R5: falling-edge mode
        restart_mode(1'b1, 1'b0);
        for (int i = 0; i < NCH; i++) gsv[i] = (37 * i + 11) % FRAME;
        apply_gs();
        do_latch();
        run_frame(0, FRAME, "R5 falling");

        // R6: unselected source is ignored, then the other source
        do_latch();
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            osc_ref = ~osc_ref;
        end
        chk(chan_on == '0, "R6 osc ignored", int'(chan_on), 0);
        run_frame(0, FRAME, "R6 ext selected");
        restart_mode(1'b0, 1'b1);
        do_latch();
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            ext_ref = ~ext_ref;
        end
        chk(chan_on == '0, "R6 ext ignored", int'(chan_on), 0);
        run_frame(0, FRAME, "R6 osc selected");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule